// File: doc/BRIEF.md
# Two-Lane SIMD Load, Store and Arithmetic Path

This block is the execution core of a two-lane integer SIMD engine. Two processing lanes each own a bank of 32-bit registers and an accumulator. They are steered by one shared command stream that has already been decoded: an operation code and three register numbers. A mode input picks the execution style. With the mode off, only the primary lane (lane 0) acts, and the block behaves as a plain scalar unit. With the mode on, each command runs in both lanes in the same cycle. The register numbers are the same in both lanes, and each lane works on its own data.

Memory is reached through a 64-bit port that carries two adjacent 32-bit words per access. The primary lane owns the addressed word and the secondary lane owns the word that follows it. A walk through an array therefore hands the even elements to lane 0 and the odd elements to lane 1. A load can split the two words across the lanes, or copy the addressed word into both lanes. Stores write the two lanes back as a pair. An internal address pointer advances after each access by the number of words used.

Complex data fits this layout directly: real parts sit in lane 0 and imaginary parts in lane 1. A complex vector add then takes two split loads, one SIMD add and one paired store per element.

Top module: `simd_lane_pair`

## Requirements
- R1: After reset, all registers of both lanes, both accumulators and the address pointer are zero, and neither `mem_re_o` nor `mem_we_o` is asserted.
- R2: With `simd_en_i` low, only lane 0 executes. No register or accumulator of lane 1 changes, except through `OP_ACC_CLR`.
- R3: With `simd_en_i` high, `OP_ADD`, `OP_MAC`, `OP_ACC_RD`, the loads and the store act in both lanes in the same cycle. Each lane reads and writes its own registers, using the shared numbers `rd_i`, `rs1_i` and `rs2_i`.
- R4: A split load (`OP_LD_SPLIT`) at pointer A reads the 64-bit word pair, with word A in bits 31:0 and word A+1 in bits 63:32. Bits 31:0 go to lane 0 register `rd`. In SIMD mode, bits 63:32 go to lane 1 register `rd`.
- R5: A broadcast load (`OP_LD_BCAST`) writes bits 31:0 of the read (word A) to register `rd`. In SIMD mode it writes this to both lanes; in single-lane mode it writes it to lane 0 only.
- R6: A load drives `mem_re_o` and `mem_addr_o` in its issue cycle and samples `mem_rdata_i` in the next cycle. It writes `rd` at the end of that next cycle.
- R7: `OP_STORE` drives `mem_we_o` and `mem_addr_o` = A, with lane 0 register `rs1` on bits 31:0 and lane 1 register `rs1` on bits 63:32. In SIMD mode `mem_be_o` is 2'b11. In single-lane mode it is 2'b01, where bit 0 enables the low word and bit 1 enables the high word.
- R8: After a split load or a store, the pointer advances by 2 in SIMD mode and by 1 in single-lane mode. After a broadcast load it always advances by 1. `addr_set_i` loads `addr_val_i` into the pointer, and this takes priority. The pointer wraps modulo 2^ADDR_W.
- R9: `OP_ADD` writes `rs1 + rs2`, modulo 2^32, to `rd` in each active lane.
- R10: `OP_MAC` adds the low 32 bits of `rs1 * rs2` to the lane accumulator, wrapping on overflow. `OP_ACC_RD` copies the lane accumulator into `rd`.
- R11: `OP_ACC_CLR` zeroes both accumulators in every mode.
- R12: Operation codes on `op_i`: 0 NOP, 1 LD_SPLIT, 2 LD_BCAST, 3 STORE, 4 ADD, 5 MAC, 6 ACC_CLR, 7 ACC_RD. A command acts only while `op_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| simd_en_i | input | 1 | 1 = both lanes execute, 0 = lane 0 only |
| op_valid_i | input | 1 | Command valid |
| op_i | input | 3 | Operation code |
| rd_i | input | 3 | Destination register number |
| rs1_i | input | 3 | First source register (store data source) |
| rs2_i | input | 3 | Second source register |
| addr_set_i | input | 1 | Load the address pointer |
| addr_val_i | input | 6 | New pointer value |
| mem_addr_o | output | 6 | Word address of the access (lane 0 word) |
| mem_re_o | output | 1 | Read request |
| mem_rdata_i | input | 64 | Read data, one cycle after the request |
| mem_we_o | output | 1 | Write request |
| mem_be_o | output | 2 | Word enables: bit 0 low word, bit 1 high word |
| mem_wdata_o | output | 64 | Write data, lane 1 in the high half |

## Verification
The assertions rely on the command stream obeying one rule. In the cycle after a load, no `OP_ADD` or `OP_ACC_RD` may target the register that the load is filling. The bench also never reads that register in that cycle, because its value is not yet written. The bench meets this rule by issuing an idle cycle after every load, whether the load is directed or random. It also never raises `addr_set_i` in the same cycle as a memory command. The memory model answers each read in the next cycle and honours both word enables.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LD_SPLIT = 3'd1,
    OP_LD_BCAST = 3'd2,
    OP_STORE    = 3'd3,
    OP_ADD      = 3'd4,
    OP_MAC      = 3'd5,
    OP_ACC_CLR  = 3'd6,
    OP_ACC_RD   = 3'd7
  } op_e;
endpackage

// File: rtl/simd_addr_gen.sv
module simd_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_val_i,
  input  logic              step_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (set_i)  addr_q <= set_val_i;
    else if (step_i) addr_q <= addr_q + (wide_i ? ADDR_W'(2) : ADDR_W'(1));
  end

  assign addr_o = addr_q;

  AST_ADDR_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && wide_i && !set_i |=> addr_q == $past(addr_q) + ADDR_W'(2)); // R8
  AST_ADDR_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wide_i && !set_i |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R8
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  op_e                     op_i,
  input  logic [$clog2(NREG)-1:0] rd_i,
  input  logic [$clog2(NREG)-1:0] rs1_i,
  input  logic [$clog2(NREG)-1:0] rs2_i,
  input  logic                    ld_we_i,
  input  logic [$clog2(NREG)-1:0] ld_rd_i,
  input  logic [DATA_W-1:0]       ld_data_i,
  output logic [DATA_W-1:0]       st_data_o
);
  logic [NREG-1:0][DATA_W-1:0] rf_q;
  logic [DATA_W-1:0] acc_q, src_a, src_b, prod, alu_res;
  logic alu_we, mac_en;

  always_comb begin
    src_a   = rf_q[rs1_i];
    src_b   = rf_q[rs2_i];
    prod    = src_a * src_b;
    alu_we  = en_i && (op_i == OP_ADD || op_i == OP_ACC_RD);
    alu_res = (op_i == OP_ADD) ? src_a + src_b : acc_q;
    mac_en  = en_i && (op_i == OP_MAC);
  end

  // ALU write is younger than a pending load write-back and wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_q <= '0;
    end else begin
      if (ld_we_i) rf_q[ld_rd_i] <= ld_data_i;
      if (alu_we)  rf_q[rd_i]    <= alu_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (mac_en) acc_q <= acc_q + prod;
  end

  assign st_data_o = src_a;

  AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0); // R11

  generate
    if (LANE != 0) begin : g_sec_chk
      AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i && !ld_we_i |=> $stable(rf_q)); // R2
    end
  endgenerate
endmodule

// File: rtl/simd_lane_pair.sv
module simd_lane_pair
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int ADDR_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    simd_en_i,
  input  logic                    op_valid_i,
  input  logic [2:0]              op_i,
  input  logic [$clog2(NREG)-1:0] rd_i,
  input  logic [$clog2(NREG)-1:0] rs1_i,
  input  logic [$clog2(NREG)-1:0] rs2_i,
  input  logic                    addr_set_i,
  input  logic [ADDR_W-1:0]       addr_val_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic                    mem_re_o,
  input  logic [2*DATA_W-1:0]     mem_rdata_i,
  output logic                    mem_we_o,
  output logic [1:0]              mem_be_o,
  output logic [2*DATA_W-1:0]     mem_wdata_o
);
  localparam int RW    = $clog2(NREG);
  localparam int LANES = 2;

  op_e  op;
  logic is_ld, is_st, step_wide, acc_clr, op_writes_rd;
  logic ld_v_q, ld_bcast_q, ld_simd_q;
  logic [RW-1:0] ld_rd_q;
  logic [LANES-1:0] lane_en, lane_ld_we;
  logic [LANES-1:0][DATA_W-1:0] lane_ld_data, lane_st_data;

  always_comb begin
    op           = op_e'(op_i);
    is_ld        = op_valid_i && (op == OP_LD_SPLIT || op == OP_LD_BCAST);
    is_st        = op_valid_i && (op == OP_STORE);
    step_wide    = simd_en_i && (op != OP_LD_BCAST);
    acc_clr      = op_valid_i && (op == OP_ACC_CLR);
    op_writes_rd = op_valid_i && (op == OP_ADD || op == OP_ACC_RD);
  end

  simd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (addr_set_i),
    .set_val_i (addr_val_i),
    .step_i    (is_ld || is_st),
    .wide_i    (step_wide),
    .addr_o    (mem_addr_o)
  );

  // load write-back stage: data arrives the cycle after the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_v_q     <= 1'b0;
      ld_bcast_q <= 1'b0;
      ld_simd_q  <= 1'b0;
      ld_rd_q    <= '0;
    end else begin
      ld_v_q     <= is_ld;
      ld_bcast_q <= (op == OP_LD_BCAST);
      ld_simd_q  <= simd_en_i;
      ld_rd_q    <= rd_i;
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_pri
        assign lane_en[l]      = op_valid_i;
        assign lane_ld_we[l]   = ld_v_q;
        assign lane_ld_data[l] = mem_rdata_i[DATA_W-1:0];
      end else begin : g_sec
        assign lane_en[l]      = op_valid_i && simd_en_i;
        assign lane_ld_we[l]   = ld_v_q && ld_simd_q;
        assign lane_ld_data[l] = ld_bcast_q ? mem_rdata_i[DATA_W-1:0]
                                            : mem_rdata_i[l*DATA_W +: DATA_W];
      end

      simd_lane #(.LANE(l), .DATA_W(DATA_W), .NREG(NREG)) u_lane (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (lane_en[l]),
        .clr_i     (acc_clr),
        .op_i      (op),
        .rd_i      (rd_i),
        .rs1_i     (rs1_i),
        .rs2_i     (rs2_i),
        .ld_we_i   (lane_ld_we[l]),
        .ld_rd_i   (ld_rd_q),
        .ld_data_i (lane_ld_data[l]),
        .st_data_o (lane_st_data[l])
      );
    end
  endgenerate

  assign mem_re_o    = is_ld;
  assign mem_we_o    = is_st;
  assign mem_be_o    = is_st ? {simd_en_i, 1'b1} : 2'b00;
  assign mem_wdata_o = lane_st_data;

  AST_LD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_v_q |-> $past(mem_re_o)); // R6
  AST_WB_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_v_q && op_writes_rd |-> rd_i != ld_rd_q); // R6
  AST_BE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !simd_en_i |-> mem_be_o == 2'b01); // R7
  AST_NO_IDLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !mem_re_o && !mem_we_o); // R12
endmodule

// File: tb/simd_lane_pair_bench.sv
module simd_lane_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic simd_en = 1'b0, op_valid = 1'b0, addr_set = 1'b0;
  logic [2:0] op = 3'd0, rd = 3'd0, rs1 = 3'd0, rs2 = 3'd0;
  logic [5:0] addr_val = 6'd0;
  logic [5:0] mem_addr;
  logic mem_re, mem_we;
  logic [1:0] mem_be;
  logic [63:0] mem_rdata = 64'd0, mem_wdata;

  logic [31:0] mem [64];
  logic [31:0] m_rf [2][8];
  logic [31:0] m_acc [2];
  logic [5:0]  m_addr;
  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  simd_lane_pair u_simd_lane_pair (
    .clk_i(clk), .rst_ni(rst_n), .simd_en_i(simd_en), .op_valid_i(op_valid),
    .op_i(op), .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2),
    .addr_set_i(addr_set), .addr_val_i(addr_val),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= {mem[mem_addr + 6'd1], mem[mem_addr]};
    if (mem_we) begin
      if (mem_be[0]) mem[mem_addr] <= mem_wdata[31:0];
      if (mem_be[1]) mem[mem_addr + 6'd1] <= mem_wdata[63:32];
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [5:0] v);
    @(negedge clk);
    op_valid = 1'b0; addr_set = 1'b1; addr_val = v;
    m_addr = v;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [2:0] d, input logic [2:0] s1,
                        input logic [2:0] s2, input logic simd);
    logic [5:0] a;
    logic [31:0] t0, t1;
    @(negedge clk);
    addr_set = 1'b0; op_valid = 1'b1; op = o; rd = d; rs1 = s1; rs2 = s2; simd_en = simd;
    #1;
    a = m_addr;
    case (o)
      3'd1: begin
        check("R6 read strobe", {63'd0, mem_re}, 64'd1);
        check("R4 address", {58'd0, mem_addr}, {58'd0, a});
        t0 = mem[a]; t1 = mem[a + 6'd1];
        m_rf[0][d] = t0;
        if (simd) m_rf[1][d] = t1;
        m_addr = a + (simd ? 6'd2 : 6'd1);
      end
      3'd2: begin
        check("R5 address", {58'd0, mem_addr}, {58'd0, a});
        t0 = mem[a];
        m_rf[0][d] = t0;
        if (simd) m_rf[1][d] = t0;
        m_addr = a + 6'd1;
      end
      3'd3: begin
        check("R7 write strobe", {63'd0, mem_we}, 64'd1);
        check("R8 address", {58'd0, mem_addr}, {58'd0, a});
        check("R7 enables", {62'd0, mem_be}, simd ? 64'd3 : 64'd1);
        check("R3 lane0 data", {32'd0, mem_wdata[31:0]}, {32'd0, m_rf[0][s1]});
        if (simd) check("R3 lane1 data", {32'd0, mem_wdata[63:32]}, {32'd0, m_rf[1][s1]});
        m_addr = a + (simd ? 6'd2 : 6'd1);
      end
      3'd4: for (int l = 0; l < 2; l++)
        if (l == 0 || simd) m_rf[l][d] = m_rf[l][s1] + m_rf[l][s2];
      3'd5: for (int l = 0; l < 2; l++)
        if (l == 0 || simd) m_acc[l] = m_acc[l] + m_rf[l][s1] * m_rf[l][s2];
      3'd6: begin m_acc[0] = 32'd0; m_acc[1] = 32'd0; end
      3'd7: for (int l = 0; l < 2; l++)
        if (l == 0 || simd) m_rf[l][d] = m_acc[l];
      default: ;
    endcase
    if (o == 3'd1 || o == 3'd2) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = $urandom(32'h1357 + i);
    for (int l = 0; l < 2; l++) begin
      m_acc[l] = 32'd0;
      for (int r = 0; r < 8; r++) m_rf[l][r] = 32'd0;
    end
    m_addr = 6'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no read", {63'd0, mem_re}, 64'd0);
    check("R1 no write", {63'd0, mem_we}, 64'd0);
    check("R1 pointer", {58'd0, mem_addr}, 64'd0);
    run_op(3'd3, 3'd0, 3'd5, 3'd0, 1'b1);   // R1 zero regs on both halves

    // complex pair add: real in lane 0, imaginary in lane 1
    set_addr(6'd8);
    @(negedge clk); addr_set = 1'b0;
    mem[8] = 32'hFFFF_FFF0; mem[9] = 32'd7; mem[10] = 32'h20; mem[11] = 32'hFFFF_FFFF;
    run_op(3'd1, 3'd1, 3'd0, 3'd0, 1'b1);
    run_op(3'd1, 3'd2, 3'd0, 3'd0, 1'b1);
    check("R8 wide step", {58'd0, mem_addr}, 64'd12);
    run_op(3'd4, 3'd3, 3'd1, 3'd2, 1'b1);
    set_addr(6'd40);
    run_op(3'd3, 3'd0, 3'd3, 3'd0, 1'b1);
    check("R9 complex sum", mem_wdata, {32'd6, 32'h10});

    // broadcast into both lanes
    set_addr(6'd20);
    run_op(3'd2, 3'd4, 3'd0, 3'd0, 1'b1);
    check("R8 bcast step", {58'd0, mem_addr}, 64'd21);
    set_addr(6'd50);
    run_op(3'd3, 3'd0, 3'd4, 3'd0, 1'b1);
    check("R5 both lanes", mem_wdata, {mem[20], mem[20]});

    // single-lane load leaves lane 1 intact
    set_addr(6'd30);
    run_op(3'd1, 3'd4, 3'd0, 3'd0, 1'b0);
    check("R8 narrow step", {58'd0, mem_addr}, 64'd31);
    run_op(3'd3, 3'd0, 3'd4, 3'd0, 1'b1);
    check("R2 lane1 kept", {32'd0, mem_wdata[63:32]}, {32'd0, mem[20]});

    // MAC with wrap, clear in single mode
    run_op(3'd5, 3'd0, 3'd1, 3'd2, 1'b1);
    run_op(3'd5, 3'd0, 3'd1, 3'd2, 1'b1);
    run_op(3'd7, 3'd6, 3'd0, 3'd0, 1'b1);
    run_op(3'd6, 3'd0, 3'd0, 3'd0, 1'b0);
    run_op(3'd7, 3'd7, 3'd0, 3'd0, 1'b1);
    run_op(3'd3, 3'd0, 3'd6, 3'd0, 1'b1);
    check("R10 acc", mem_wdata, {32'd14 * 32'hFFFF_FFFF, 32'hFFFF_FFF0 * 32'h20 * 32'd2});
    run_op(3'd3, 3'd0, 3'd7, 3'd0, 1'b1);
    check("R11 cleared", mem_wdata, 64'd0);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 800; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) set_addr(6'($urandom));
      run_op(o, 3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom));
    end
    for (int r = 0; r < 8; r++) run_op(3'd3, 3'd0, 3'(r), 3'd0, 1'b1);  // R3 final state
    @(negedge clk);
    op_valid = 1'b0; addr_set = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule